// File: doc/BRIEF.md
# Reference Selection and Holdover Controller

This block decides, once per master-clock cycle, which of two timing references a downstream phase-locked loop should follow and whether that loop should track the reference, hold its last frequency, or run free. A two-bit mode input either forces one of three manual operating states or hands control to an automatic state machine. In the manual states a single select input picks the physical reference directly.

In automatic mode the machine watches two loss indicators: one flags loss of the preferred reference, the other loss of the alternate. It steps between five states: free-run, tracking the preferred input, tracking the alternate, holding after the preferred input was lost, and holding after the alternate was lost. A loss of the preferred reference alone does not switch inputs at once. The machine first holds for a programmable guard interval, counted in master-clock cycles, so that brief dropouts never move the loop onto the other source. The select input still matters in automatic mode: it swaps which physical input counts as preferred.

Both outputs are registered. Each reflects the inputs sampled at the preceding clock edge.

Top module: `ref_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `pll_mode` is 2'b10 (free-run) and `use_alt` is 0. The automatic machine starts in its free-run state whatever the loss inputs are.
- R2: `pll_mode` uses the encoding 2'b00 = track, 2'b01 = hold, 2'b10 = free-run and never shows 2'b11. With `mode_sel` at 2'b00, 2'b01 or 2'b10 (manual), `pll_mode` equals `mode_sel` one cycle later.
- R3: In a manual mode (`mode_sel` not 2'b11), `use_alt` equals the `ref_swap` value sampled at the preceding edge. Here 0 means the physical input A and 1 means input B.
- R4: In automatic mode (`mode_sel` = 2'b11), `loss_pri` = 0 moves any state to tracking the preferred input, whatever `loss_sec` is.
- R5: In automatic mode with both loss inputs at 1, tracking-preferred goes to holding-preferred and tracking-alternate goes to holding-alternate. Free-run and both holding states are kept.
- R6: In automatic mode with only `loss_pri` = 1, free-run goes to tracking-alternate, holding-alternate goes to tracking-alternate, and tracking-alternate is kept.
- R7: With only `loss_pri` = 1, tracking-preferred enters holding-preferred and loads the guard counter with `guard_len`. The machine stays in holding-preferred for `guard_len` further edges, during which the counter runs whatever the loss inputs are. At the next edge that sees only `loss_pri` = 1, it moves to tracking-alternate. A `guard_len` of 0 switches at the first such edge.
- R8: Recovery of the preferred input (`loss_pri` = 0) during the guard interval returns the machine to tracking-preferred and clears the counter. A later loss reloads the full guard interval.
- R9: In automatic mode, `use_alt` is `ref_swap` XOR 0 for free-run and the preferred states, and `ref_swap` XOR 1 for the alternate states. `pll_mode` is track for the tracking states, hold for the holding states and free-run for free-run.
- R10: Any cycle with `mode_sel` not 2'b11 discards the automatic state. The first automatic cycle after that evaluates its transition from free-run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Operating mode: 00 track, 01 hold, 10 free-run, 11 automatic |
| ref_swap | input | 1 | Manual reference pick; in automatic mode, swaps preferred and alternate |
| loss_pri | input | 1 | Loss of the currently preferred reference |
| loss_sec | input | 1 | Loss of the currently alternate reference |
| guard_len | input | GUARD_W | Guard interval in master-clock cycles |
| pll_mode | output | 2 | Loop state: 00 track, 01 hold, 10 free-run |
| use_alt | output | 1 | Physical reference selected: 0 input A, 1 input B |

## Verification
The bench builds the block with `GUARD_W` = 5, so guard intervals of 0, 1, 3 and 31 cycles can each be exhausted within a few dozen cycles. This makes the expiry edge, the zero-length interval and the reload after recovery all directly observable. Long random runs biased towards automatic mode and the primary-only loss pattern drive every state through every loss pattern. They also toggle the swap input and the manual modes at arbitrary points in the guard countdown.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    AS_FREE   = 3'd0,
    AS_NORM_P = 3'd1,
    AS_NORM_S = 3'd2,
    AS_HOLD_P = 3'd3,
    AS_HOLD_S = 3'd4
  } auto_st_e;

  typedef enum logic [1:0] {
    PM_TRACK = 2'b00,
    PM_HOLD  = 2'b01,
    PM_FREE  = 2'b10
  } pll_mode_e;

  localparam logic [1:0] MS_AUTO = 2'b11;
endpackage

// File: rtl/ras_guard_timer.sv
module ras_guard_timer #(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic               clear,
  input  logic [GUARD_W-1:0] len,
  output logic               expired
);
  logic [GUARD_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = load | clear | (run & (cnt_q != '0));
    if (clear)     cnt_d = '0;
    else if (load) cnt_d = len;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R7: once expired, a running counter stays expired
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && !load && !clear) |=> expired);
endmodule

// File: rtl/ras_next_state.sv
module ras_next_state
  import ras_pkg::*;
(
  input  auto_st_e cur,
  input  logic     auto_en,
  input  logic     loss_pri,
  input  logic     loss_sec,
  input  logic     guard_done,
  output auto_st_e nxt
);
  always_comb begin
    nxt = cur;
    if (!auto_en) begin
      nxt = AS_FREE;
    end else if (!loss_pri) begin
      nxt = AS_NORM_P;
    end else if (loss_sec) begin
      case (cur)
        AS_NORM_P: nxt = AS_HOLD_P;
        AS_NORM_S: nxt = AS_HOLD_S;
        AS_FREE, AS_HOLD_P, AS_HOLD_S: nxt = cur;
        default:   nxt = AS_FREE;
      endcase
    end else begin
      case (cur)
        AS_FREE:   nxt = AS_NORM_S;
        AS_NORM_P: nxt = AS_HOLD_P;
        AS_NORM_S: nxt = AS_NORM_S;
        AS_HOLD_S: nxt = AS_NORM_S;
        AS_HOLD_P: nxt = guard_done ? AS_NORM_S : AS_HOLD_P;
        default:   nxt = AS_FREE;
      endcase
    end
  end
endmodule

// File: rtl/ras_out_map.sv
module ras_out_map
  import ras_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       ref_swap,
  input  auto_st_e   st,
  output pll_mode_e  mode_d,
  output logic       alt_d
);
  logic on_alternate;

  always_comb begin
    on_alternate = (st == AS_NORM_S) || (st == AS_HOLD_S);
    if (mode_sel != MS_AUTO) begin
      mode_d = pll_mode_e'(mode_sel);
      alt_d  = ref_swap;
    end else begin
      alt_d = ref_swap ^ on_alternate;
      case (st)
        AS_NORM_P, AS_NORM_S: mode_d = PM_TRACK;
        AS_HOLD_P, AS_HOLD_S: mode_d = PM_HOLD;
        default:              mode_d = PM_FREE;
      endcase
    end
  end
endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter
  import ras_pkg::*;
#(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               ref_swap,
  input  logic               loss_pri,
  input  logic               loss_sec,
  input  logic [GUARD_W-1:0] guard_len,
  output logic [1:0]         pll_mode,
  output logic               use_alt
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  auto_st_e   state_q, state_d;
  pll_mode_e  mode_d;
  logic       alt_d;
  logic       auto_en, guard_done;
  logic       g_load, g_run, g_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign auto_en = (mode_sel == MS_AUTO);

  ras_next_state u_nxt (
    .cur        (state_q),
    .auto_en    (auto_en),
    .loss_pri   (loss_pri),
    .loss_sec   (loss_sec),
    .guard_done (guard_done),
    .nxt        (state_d)
  );

  always_comb begin
    g_load  = (state_d == AS_HOLD_P) && (state_q != AS_HOLD_P);
    g_run   = (state_d == AS_HOLD_P) && (state_q == AS_HOLD_P);
    g_clear = (state_d != AS_HOLD_P);
  end

  ras_guard_timer #(.GUARD_W(GUARD_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_s),
    .load    (g_load),
    .run     (g_run),
    .clear   (g_clear),
    .len     (guard_len),
    .expired (guard_done)
  );

  ras_out_map u_map (
    .mode_sel (mode_sel),
    .ref_swap (ref_swap),
    .st       (state_d),
    .mode_d   (mode_d),
    .alt_d    (alt_d)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q  <= AS_FREE;
      pll_mode <= PM_FREE;
      use_alt  <= 1'b0;
    end else begin
      state_q  <= state_d;
      pll_mode <= mode_d;
      use_alt  <= alt_d;
    end
  end

  // R2: output code 2'b11 never appears
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |-> (pll_mode != 2'b11));
  // R2: manual hold request shows as hold
  a_r2_manual_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_sel == 2'b01) |=> (pll_mode == 2'b01));
  // R3: manual mode follows the select input
  a_r3_manual_sel: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_sel != MS_AUTO) |=> (use_alt == $past(ref_swap)));
  // R4: preferred input present means tracking it
  a_r4_recover: assert property (@(posedge clk) disable iff (!rst_s)
    (auto_en && !loss_pri) |=> (pll_mode == 2'b00 && use_alt == $past(ref_swap)));
  // R7: guard not yet run out keeps holding on preferred
  a_r7_guard_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (auto_en && state_q == AS_HOLD_P && loss_pri && !loss_sec && !guard_done)
      |=> (state_q == AS_HOLD_P));
  // R10: manual cycles discard the automatic state
  a_r10_discard: assert property (@(posedge clk) disable iff (!rst_s)
    (!auto_en) |=> (state_q == AS_FREE));
endmodule

// File: tb/ref_arbiter_tb.sv
module ref_arbiter_tb;
  localparam int GW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b10;
  logic          ref_swap = 1'b0;
  logic          loss_pri = 1'b0;
  logic          loss_sec = 1'b0;
  logic [GW-1:0] guard_len = '0;
  logic [1:0]    pll_mode;
  logic          use_alt;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state: 0 free, 1 track-pref, 2 track-alt, 3 hold-pref, 4 hold-alt
  int m_st = 0;
  int m_cnt = 0;
  int e_mode = 2;
  int e_alt = 0;

  always #2 clk = ~clk;

  ref_arbiter #(.GUARD_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_swap(ref_swap),
    .loss_pri(loss_pri), .loss_sec(loss_sec), .guard_len(guard_len),
    .pll_mode(pll_mode), .use_alt(use_alt)
  );

  task automatic model_edge();
    int ns;
    if (mode_sel != 2'b11) begin
      m_st = 0; m_cnt = 0;
      e_mode = mode_sel; e_alt = ref_swap;
      return;
    end
    ns = m_st;
    if (!loss_pri) ns = 1;
    else if (loss_sec) begin
      if (m_st == 1) ns = 3;
      else if (m_st == 2) ns = 4;
    end else begin
      if (m_st == 0 || m_st == 4) ns = 2;
      else if (m_st == 1) ns = 3;
      else if (m_st == 3 && m_cnt == 0) ns = 2;
    end
    if (ns == 3 && m_st != 3) m_cnt = guard_len;
    else if (ns != 3) m_cnt = 0;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_st = ns;
    e_mode = (m_st == 0) ? 2 : (m_st <= 2) ? 0 : 1;
    e_alt = ref_swap ^ ((m_st == 2 || m_st == 4) ? 1 : 0);
  endtask

  task automatic compare(string tag);
    vectors++;
    if (pll_mode !== 2'(e_mode) || use_alt !== 1'(e_alt)) begin
      fails++;
      $display("FAIL %s: pll_mode=%0d use_alt=%0d expected pll_mode=%0d use_alt=%0d",
               tag, pll_mode, use_alt, e_mode, e_alt);
    end
  endtask

  task automatic step(input logic [1:0] ms, input logic sw, input logic lp,
                      input logic ls, input string tag);
    @(negedge clk);
    mode_sel = ms; ref_swap = sw; loss_pri = lp; loss_sec = ls;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state, loss inputs active
    loss_pri = 1'b1; loss_sec = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1 after release");

    // R2 / R3 manual modes
    step(2'b00, 1'b0, 1'b1, 1'b1, "R2 manual track");
    step(2'b01, 1'b1, 1'b0, 1'b0, "R2 manual hold");
    step(2'b10, 1'b1, 1'b0, 1'b0, "R2 manual free");
    step(2'b00, 1'b1, 1'b0, 1'b0, "R3 select B");
    step(2'b00, 1'b0, 1'b0, 1'b0, "R3 select A");

    // R10 entry from free-run; R6 free -> alternate
    step(2'b11, 1'b0, 1'b1, 1'b0, "R10 entry R6 free to alt");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R6 alt kept");
    step(2'b11, 1'b0, 1'b1, 1'b1, "R5 alt to hold-alt");
    step(2'b11, 1'b0, 1'b1, 1'b1, "R5 hold-alt kept");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R6 hold-alt to alt");
    step(2'b11, 1'b0, 1'b0, 1'b1, "R4 back to preferred");

    // R7 guard of 3 cycles
    guard_len = 5'd3;
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 enter hold-pref");
    step(2'b11, 1'b0, 1'b1, 1'b1, "R7 guard runs under double loss");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 guard 1");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 guard 2");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 expiry switch");
    // R8 recover mid-guard and reload
    step(2'b11, 1'b0, 1'b0, 1'b0, "R8 recover");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R8 reload");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R8 mid-guard");
    step(2'b11, 1'b0, 1'b0, 1'b1, "R8 recover again");
    // R7 zero guard
    guard_len = 5'd0;
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 zero guard enter");
    step(2'b11, 1'b0, 1'b1, 1'b0, "R7 zero guard switch");
    // R9 swap roles
    step(2'b11, 1'b1, 1'b1, 1'b0, "R9 swapped alt");
    step(2'b11, 1'b1, 1'b0, 1'b0, "R9 swapped preferred");
    // R10 leave and re-enter
    guard_len = 5'd31;
    step(2'b11, 1'b0, 1'b1, 1'b0, "R10 hold-pref long guard");
    step(2'b01, 1'b0, 1'b1, 1'b0, "R10 leave auto");
    step(2'b11, 1'b0, 1'b1, 1'b1, "R10 reentry free kept");

    // random: R11-style mixed coverage of all requirements
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] ms;
      logic lp, ls;
      ms = ($urandom_range(0, 9) < 8) ? 2'b11 : 2'($urandom_range(0, 2));
      lp = ($urandom_range(0, 3) != 0);
      ls = ($urandom_range(0, 3) == 0);
      if ((i % 400) == 0) guard_len = GW'($urandom_range(0, 31));
      step(ms, ($urandom_range(0, 7) == 0) ? ~ref_swap : ref_swap, lp, ls,
           "R9 random mix");
    end
    finish_run();
  end
endmodule